// File: doc/BRIEF.md
# Base-Link Pixel Tap Unpacker

This block sits behind a 28-bit parallel video receiver and runs on the receiver's pixel clock. On every cycle it samples three 8-bit data ports (A, B, C) and three qualifying strobes: frame valid, line valid and data valid. A pixel counts as accepted only on a cycle where all three strobes are high. The block then splits the 24 data bits into one, two or three tap values. The split depends on a run-time mode: three 8-bit colour channels, two 12-bit taps, two 10-bit taps, or one 8-bit mono tap. The taps can optionally be emitted in reversed order.

Each accepted pixel appears one clock later on the tap outputs with a one-cycle valid pulse. Alongside it come start-of-frame and start-of-line flags, the pixel's index within its line and the line's index within its frame. Mode and reversal are captured only between frames, so one frame is always decoded with a single setting.

Top module: `base_tap_unpacker`

## Requirements
- R1: A pixel is accepted only on a cycle where frame valid, line valid and data valid are all 1. `pix_vld_o` is 1 exactly one clock after an accepted cycle and 0 otherwise.
- R2: Mode 2'b00 (three 8-bit colour channels): tap0 = A, tap1 = B, tap2 = C, each zero-extended.
- R3: Mode 2'b01 (two 12-bit taps): tap0 = {B[3:0], A}, tap1 = {B[7:4], C}, tap2 = 0.
- R4: Mode 2'b10 (two 10-bit taps): tap0 = {B[1:0], A}, tap1 = {B[5:4], C}, tap2 = 0. Bits B[3:2] and B[7:6] have no effect on any output.
- R5: Mode 2'b11 (one 8-bit mono tap): tap0 = A, tap1 = tap2 = 0.
- R6: With reversal set to 1, the active taps come out in the opposite order. In three-tap mode tap0 and tap2 swap. In two-tap modes tap0 and tap1 swap. Mono mode is unchanged.
- R7: Mode and reversal are captured on every clock where frame valid is 0 and held while it is 1. Changing them during a frame does not alter how that frame is decoded.
- R8: `sof_o` is 1 with the first accepted pixel after frame valid rises, and 0 for every other output.
- R9: `sol_o` is 1 with the first accepted pixel after line valid rises, and 0 for every other output.
- R10: `pix_cnt_o` gives the pixel's zero-based index within its line. The index restarts at 0 when line valid rises.
- R11: `line_cnt_o` gives the line's zero-based index. It increments on each falling edge of line valid and restarts at 0 when frame valid rises.
- R12: Between valid pulses the taps and both counts hold their last values, and `sof_o` and `sol_o` stay 0.
- R13: While `rst_ni` is 0, all outputs are 0 and the captured setting is three-tap colour, not reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_a_i | input | 8 | Data port A |
| port_b_i | input | 8 | Data port B |
| port_c_i | input | 8 | Data port C |
| frame_vld_i | input | 1 | Frame valid strobe |
| line_vld_i | input | 1 | Line valid strobe |
| data_vld_i | input | 1 | Data valid strobe |
| mode_i | input | 2 | Tap split mode (00 colour, 01 2x12, 10 2x10, 11 mono) |
| rev_i | input | 1 | Tap order reversal |
| tap0_o | output | TAP_W | Tap 0 value |
| tap1_o | output | TAP_W | Tap 1 value |
| tap2_o | output | TAP_W | Tap 2 value |
| pix_vld_o | output | 1 | Pixel output valid pulse |
| sof_o | output | 1 | Start-of-frame flag |
| sol_o | output | 1 | Start-of-line flag |
| pix_cnt_o | output | PIX_W | Pixel index within line |
| line_cnt_o | output | LINE_W | Line index within frame |

## Verification
The bench uses the default parameters: 12-bit taps and 16-bit pixel and line counters. This allows every bit of the widest 12-bit split to be compared, including the zero-extended colour and mono taps. Sixteen-bit counters do not wrap within the short frames driven here, so each index is compared directly against its exact expected value. Every mode and reversal pair is forced across successive frames. Mode changes are scattered through each frame's active region, and data valid is dropped at random, so settings capture and all three-strobe qualification are exercised alongside the tap mapping.

// File: rtl/tap_unpack_pkg.sv
package tap_unpack_pkg;
  localparam int PORT_W = 8;
  localparam int MAX_TAPS = 3;

  typedef enum logic [1:0] {
    MODE_RGB8   = 2'b00,
    MODE_DUAL12 = 2'b01,
    MODE_DUAL10 = 2'b10,
    MODE_MONO8  = 2'b11
  } unpack_mode_e;

  typedef struct packed {
    unpack_mode_e mode;
    logic         rev;
  } unpack_cfg_t;
endpackage

// File: rtl/unpack_cfg_latch.sv
module unpack_cfg_latch
  import tap_unpack_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        frame_vld_i,
  input  logic [1:0]  mode_i,
  input  logic        rev_i,
  output unpack_cfg_t cfg_o
);
  unpack_cfg_t cfg_q;

  // setting only moves while no frame is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: MODE_RGB8, rev: 1'b0};
    end else if (!frame_vld_i) begin
      cfg_q <= '{mode: unpack_mode_e'(mode_i), rev: rev_i};
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/unpack_tap_mux.sv
module unpack_tap_mux
  import tap_unpack_pkg::*;
#(
  parameter int TAP_W = 12
) (
  input  logic [PORT_W-1:0]                port_a_i,
  input  logic [PORT_W-1:0]                port_b_i,
  input  logic [PORT_W-1:0]                port_c_i,
  input  unpack_cfg_t                      cfg_i,
  output logic [MAX_TAPS-1:0][TAP_W-1:0]   taps_o
);
  logic [MAX_TAPS-1:0][TAP_W-1:0] nat;
  logic [1:0]                     n_act;

  always_comb begin
    nat   = '0;
    n_act = 2'd1;
    unique case (cfg_i.mode)
      MODE_RGB8: begin
        nat[0] = TAP_W'(port_a_i);
        nat[1] = TAP_W'(port_b_i);
        nat[2] = TAP_W'(port_c_i);
        n_act  = 2'd3;
      end
      MODE_DUAL12: begin
        nat[0] = TAP_W'({port_b_i[3:0], port_a_i});
        nat[1] = TAP_W'({port_b_i[7:4], port_c_i});
        n_act  = 2'd2;
      end
      MODE_DUAL10: begin
        nat[0] = TAP_W'({port_b_i[1:0], port_a_i});
        nat[1] = TAP_W'({port_b_i[5:4], port_c_i});
        n_act  = 2'd2;
      end
      MODE_MONO8: begin
        nat[0] = TAP_W'(port_a_i);
        n_act  = 2'd1;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < MAX_TAPS; g++) begin : g_tap
    logic [1:0] src;
    assign src = 2'(n_act - 2'(g) - 2'd1);
    always_comb begin
      taps_o[g] = '0;
      if (!cfg_i.rev) begin
        taps_o[g] = nat[g];
      end else if (2'(g) < n_act) begin
        taps_o[g] = nat[src];
      end
    end
  end
endmodule

// File: rtl/unpack_framer.sv
module unpack_framer #(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic              line_vld_i,
  input  logic              data_vld_i,
  output logic              accept_o,
  output logic              sof_o,
  output logic              sol_o,
  output logic [PIX_W-1:0]  pix_idx_o,
  output logic [LINE_W-1:0] line_idx_o
);
  logic              fval_q, lval_q;
  logic              sof_pend_q, sol_pend_q;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              f_rise, l_rise, l_fall, sof_arm, sol_arm;

  assign f_rise   = frame_vld_i & ~fval_q;
  assign l_rise   = line_vld_i & ~lval_q;
  assign l_fall   = ~line_vld_i & lval_q;
  assign accept_o = frame_vld_i & line_vld_i & data_vld_i;
  assign sof_arm  = f_rise | sof_pend_q;
  assign sol_arm  = l_rise | sol_pend_q;
  assign sof_o    = accept_o & sof_arm;
  assign sol_o    = accept_o & sol_arm;
  assign pix_idx_o  = l_rise ? '0 : pix_q;
  assign line_idx_o = f_rise ? '0 : line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q     <= 1'b0;
      lval_q     <= 1'b0;
      sof_pend_q <= 1'b0;
      sol_pend_q <= 1'b0;
      pix_q      <= '0;
      line_q     <= '0;
    end else begin
      fval_q     <= frame_vld_i;
      lval_q     <= line_vld_i;
      sof_pend_q <= accept_o ? 1'b0 : sof_arm;
      sol_pend_q <= accept_o ? 1'b0 : sol_arm;
      if (accept_o)    pix_q <= pix_idx_o + PIX_W'(1);
      else if (l_rise) pix_q <= '0;
      if (f_rise)      line_q <= '0;
      else if (l_fall) line_q <= line_q + LINE_W'(1);
    end
  end
endmodule

// File: rtl/base_tap_unpacker.sv
module base_tap_unpacker
  import tap_unpack_pkg::*;
#(
  parameter int TAP_W  = 12,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        port_a_i,
  input  logic [7:0]        port_b_i,
  input  logic [7:0]        port_c_i,
  input  logic              frame_vld_i,
  input  logic              line_vld_i,
  input  logic              data_vld_i,
  input  logic [1:0]        mode_i,
  input  logic              rev_i,
  output logic [TAP_W-1:0]  tap0_o,
  output logic [TAP_W-1:0]  tap1_o,
  output logic [TAP_W-1:0]  tap2_o,
  output logic              pix_vld_o,
  output logic              sof_o,
  output logic              sol_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o
);
  localparam int MIN_TAP_W = PORT_W + 4;

  unpack_cfg_t                    cfg;
  logic [MAX_TAPS-1:0][TAP_W-1:0] taps_d, taps_q;
  logic                           accept, sof_d, sol_d;
  logic [PIX_W-1:0]               pix_idx;
  logic [LINE_W-1:0]              line_idx;

  initial begin
    if (TAP_W < MIN_TAP_W) $error("TAP_W must hold a 12-bit tap");
  end

  unpack_cfg_latch u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld_i),
    .mode_i      (mode_i),
    .rev_i       (rev_i),
    .cfg_o       (cfg)
  );

  unpack_tap_mux #(.TAP_W(TAP_W)) u_mux (
    .port_a_i (port_a_i),
    .port_b_i (port_b_i),
    .port_c_i (port_c_i),
    .cfg_i    (cfg),
    .taps_o   (taps_d)
  );

  unpack_framer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld_i),
    .line_vld_i  (line_vld_i),
    .data_vld_i  (data_vld_i),
    .accept_o    (accept),
    .sof_o       (sof_d),
    .sol_o       (sol_d),
    .pix_idx_o   (pix_idx),
    .line_idx_o  (line_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_q     <= '0;
      pix_vld_o  <= 1'b0;
      sof_o      <= 1'b0;
      sol_o      <= 1'b0;
      pix_cnt_o  <= '0;
      line_cnt_o <= '0;
    end else begin
      pix_vld_o <= accept;
      sof_o     <= sof_d;
      sol_o     <= sol_d;
      if (accept) begin
        taps_q     <= taps_d;
        pix_cnt_o  <= pix_idx;
        line_cnt_o <= line_idx;
      end
    end
  end

  assign tap0_o = taps_q[0];
  assign tap1_o = taps_q[1];
  assign tap2_o = taps_q[2];
endmodule

// File: rtl/unpack_chk.sv
module unpack_chk #(
  parameter int TAP_W  = 12,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld_i,
  input logic              line_vld_i,
  input logic              data_vld_i,
  input logic [TAP_W-1:0]  tap0_o,
  input logic [TAP_W-1:0]  tap1_o,
  input logic [TAP_W-1:0]  tap2_o,
  input logic              pix_vld_o,
  input logic              sof_o,
  input logic              sol_o,
  input logic [PIX_W-1:0]  pix_cnt_o,
  input logic [LINE_W-1:0] line_cnt_o
);
  // R1
  qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_vld_o |-> $past(frame_vld_i && line_vld_i && data_vld_i));
  // R1
  dval_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_vld_i |=> !pix_vld_o);
  // R8
  sof_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> pix_vld_o);
  // R9
  sol_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> pix_vld_o);
  // R10
  sol_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> pix_cnt_o == '0);
  // R11
  sof_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> line_cnt_o == '0);
  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> ($stable(tap0_o) && $stable(tap1_o) && $stable(tap2_o)
                    && $stable(pix_cnt_o) && $stable(line_cnt_o)));
endmodule

bind base_tap_unpacker unpack_chk #(
  .TAP_W(TAP_W), .PIX_W(PIX_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_vld_i (frame_vld_i),
  .line_vld_i  (line_vld_i),
  .data_vld_i  (data_vld_i),
  .tap0_o      (tap0_o),
  .tap1_o      (tap1_o),
  .tap2_o      (tap2_o),
  .pix_vld_o   (pix_vld_o),
  .sof_o       (sof_o),
  .sol_o       (sol_o),
  .pix_cnt_o   (pix_cnt_o),
  .line_cnt_o  (line_cnt_o)
);

// File: tb/tb_base_tap_unpacker.sv
module tb_base_tap_unpacker;
  localparam int TAP_W  = 12;
  localparam int PIX_W  = 16;
  localparam int LINE_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] a = '0, b = '0, c = '0;
  logic fv = 1'b0, lv = 1'b0, dv = 1'b0;
  logic [1:0] mode = '0;
  logic rev = 1'b0;
  logic [TAP_W-1:0] t0, t1, t2;
  logic pv, sof, sol;
  logic [PIX_W-1:0] pc;
  logic [LINE_W-1:0] lc;

  int n_cmp = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  base_tap_unpacker #(.TAP_W(TAP_W), .PIX_W(PIX_W), .LINE_W(LINE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .port_a_i(a), .port_b_i(b), .port_c_i(c),
    .frame_vld_i(fv), .line_vld_i(lv), .data_vld_i(dv), .mode_i(mode), .rev_i(rev),
    .tap0_o(t0), .tap1_o(t1), .tap2_o(t2), .pix_vld_o(pv), .sof_o(sof), .sol_o(sol),
    .pix_cnt_o(pc), .line_cnt_o(lc)
  );

  // reference state
  logic [1:0] m_mode = '0;
  logic m_rev = 1'b0;
  logic m_pf = 0, m_pl = 0, m_spend = 0, m_lpend = 0;
  logic [PIX_W-1:0] m_pcnt = '0;
  logic [LINE_W-1:0] m_lcnt = '0;
  logic [TAP_W-1:0] e_t0 = '0, e_t1 = '0, e_t2 = '0;
  logic e_pv = 0, e_sof = 0, e_sol = 0;
  logic [PIX_W-1:0] e_pc = '0;
  logic [LINE_W-1:0] e_lc = '0;
  logic [1:0] e_mode = '0;
  logic e_rev = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3*TAP_W-1:0] ref_taps(logic [7:0] pa, logic [7:0] pb,
                                                  logic [7:0] pcc, logic [1:0] md, logic rv);
    logic [TAP_W-1:0] x0, x1, x2;
    x0 = '0; x1 = '0; x2 = '0;
    case (md)
      2'b00: begin x0 = TAP_W'(pa); x1 = TAP_W'(pb); x2 = TAP_W'(pcc); end
      2'b01: begin x0 = TAP_W'({pb[3:0], pa}); x1 = TAP_W'({pb[7:4], pcc}); end
      2'b10: begin x0 = TAP_W'({pb[1:0], pa}); x1 = TAP_W'({pb[5:4], pcc}); end
      default: x0 = TAP_W'(pa);
    endcase
    if (rv) begin
      if (md == 2'b00) return {x0, x1, x2};
      if (md != 2'b11) return {x2, x0, x1};
    end
    return {x2, x1, x0};
  endfunction

  function automatic string tap_req(logic [1:0] md, logic rv);
    if (rv && md != 2'b11) return "R6";
    case (md)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // drive one cycle at the falling edge, compare one cycle later
  task automatic cyc(logic [7:0] na, logic [7:0] nb, logic [7:0] nc,
                     logic nf, logic nl, logic nd, logic [1:0] nm, logic nr);
    logic acc, fr, lr, lf, sarm, larm;
    logic [PIX_W-1:0] pidx;
    logic [LINE_W-1:0] lidx;
    a = na; b = nb; c = nc; fv = nf; lv = nl; dv = nd; mode = nm; rev = nr;
    acc = nf & nl & nd;
    fr = nf & ~m_pf; lr = nl & ~m_pl; lf = ~nl & m_pl;
    sarm = fr | m_spend; larm = lr | m_lpend;
    pidx = lr ? '0 : m_pcnt;
    lidx = fr ? '0 : m_lcnt;
    e_pv = acc;
    e_sof = acc & sarm;
    e_sol = acc & larm;
    if (acc) begin
      {e_t2, e_t1, e_t0} = ref_taps(na, nb, nc, m_mode, m_rev);
      e_mode = m_mode; e_rev = m_rev;
      e_pc = pidx; e_lc = lidx;
    end
    m_spend = acc ? 1'b0 : sarm;
    m_lpend = acc ? 1'b0 : larm;
    if (acc) m_pcnt = pidx + PIX_W'(1);
    else if (lr) m_pcnt = '0;
    if (fr) m_lcnt = '0;
    else if (lf) m_lcnt = m_lcnt + LINE_W'(1);
    m_pf = nf; m_pl = nl;
    if (!nf) begin m_mode = nm; m_rev = nr; end
    @(negedge clk);
    chk("R1", "pix_vld", 32'(pv), 32'(e_pv));
    chk(e_pv ? "R8" : "R12", "sof", 32'(sof), 32'(e_sof));
    chk(e_pv ? "R9" : "R12", "sol", 32'(sol), 32'(e_sol));
    chk(e_pv ? tap_req(e_mode, e_rev) : "R12", "tap0", 32'(t0), 32'(e_t0));
    chk(e_pv ? tap_req(e_mode, e_rev) : "R12", "tap1", 32'(t1), 32'(e_t1));
    chk(e_pv ? tap_req(e_mode, e_rev) : "R12", "tap2", 32'(t2), 32'(e_t2));
    chk(e_pv ? "R10" : "R12", "pix_cnt", 32'(pc), 32'(e_pc));
    chk(e_pv ? "R11" : "R12", "line_cnt", 32'(lc), 32'(e_lc));
  endtask

  task automatic rnd_cyc(logic nf, logic nl, logic nd, logic [1:0] nm, logic nr);
    cyc(8'($urandom), 8'($urandom), 8'($urandom), nf, nl, nd, nm, nr);
  endtask

  task automatic frame(int lines, int pix, logic [1:0] md, logic rv);
    int gap;
    gap = $urandom_range(1, 4);
    for (int i = 0; i < gap; i++) rnd_cyc(1'b0, 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    rnd_cyc(1'b0, 1'b0, 1'($urandom), md, rv);
    rnd_cyc(1'b1, 1'b0, 1'($urandom), 2'($urandom), 1'($urandom));
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < pix; p++)
        rnd_cyc(1'b1, 1'b1, ($urandom_range(0, 3) != 0), 2'($urandom), 1'($urandom));
      rnd_cyc(1'b1, 1'b0, 1'($urandom), 2'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13", "pix_vld", 32'(pv), 0);
    chk("R13", "sof", 32'(sof), 0);
    chk("R13", "sol", 32'(sol), 0);
    chk("R13", "tap0", 32'(t0), 0);
    chk("R13", "tap1", 32'(t1), 0);
    chk("R13", "tap2", 32'(t2), 0);
    chk("R13", "pix_cnt", 32'(pc), 0);
    chk("R13", "line_cnt", 32'(lc), 0);
    rst_ni = 1'b1;
    // R13 captured default: colour, forward order (fval held high from the start)
    cyc(8'h11, 8'h22, 8'h33, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1);
    chk("R13", "default tap2", 32'(t2), 32'h033);
    cyc(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0);
    // R3 directed straddle: B=0xA5 split across taps
    cyc(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
    cyc(8'h3C, 8'hA5, 8'hC3, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1);
    chk("R3", "tap0 straddle", 32'(t0), 32'h53C);
    chk("R3", "tap1 straddle", 32'(t1), 32'hAC3);
    // R7 mode changed mid-frame still decoded as 12-bit
    cyc(8'hFF, 8'h0F, 8'h01, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1);
    chk("R7", "tap1 mid-frame", 32'(t1), 32'h001);
    cyc(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);
    // R4 unused B bits have no effect
    cyc(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    cyc(8'h12, 8'hCC, 8'h34, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R4", "tap0 unused B", 32'(t0), 32'h012);
    chk("R4", "tap1 unused B", 32'(t1), 32'h034);
    // R1 line valid while frame low: nothing accepted
    cyc(8'h77, 8'h77, 8'h77, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R1", "no accept fval low", 32'(pv), 0);
    cyc(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 24; k++)
      frame($urandom_range(2, 5), $urandom_range(4, 24), 2'(k % 4), 1'((k / 4) % 2));
    repeat (4) rnd_cyc(1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule